// File: doc/BRIEF.md
# I/O Chip-Select Decoder with Wait Insertion

This block sits on a 16-bit I/O address bus and turns an address, the address-enable line (AEN) and the active-low I/O read and write strobes into registered chip selects. There are two selects: one for a DMA controller that owns a 16-port window at the bottom of the I/O space, and a write-only select for a DMA segment register that owns a four-port window at 0x80. Whenever either select is active, the block also drives the enable and direction controls of the data-bus buffer.

The same block produces the READY line for I/O cycles. Each new I/O strobe forces one wait state. This holds whether the CPU (AEN low) or the DMA controller (AEN high) owns the bus. After that forced wait, READY stays low while an external wait request is present. It also stays low while an I/O read strobe is held, and releases when that strobe drops or a memory strobe appears. The read extension can be removed with a parameter.

Top module: `io_csel_wait`

## Requirements
- R1: No select asserts unless address bits 15..8 are all zero. The address 0x0105, for example, selects nothing.
- R2: `dma_cs_no` goes low one clock after a cycle where the address is 0x0000..0x000F, AEN is low and `ior_ni` or `iow_ni` is low. Otherwise it is high.
- R3: `seg_cs_no` goes low one clock after a cycle where the address is 0x0080..0x0083, AEN is low and `iow_ni` is low. A read in that window, 0x0084, or AEN high gives no select.
- R4: `buf_en_no` is low exactly when either select is low. `dir_o` is 1 (toward the CPU) one clock after a cycle with `ior_ni` low, and 0 otherwise. It is registered together with the selects.
- R5: On the first clock where `ior_ni` or `iow_ni` is seen low after both were high, `ready_o` goes low for the following clock. This applies with AEN low or high.
- R6: After the forced wait, `ready_o` stays low while `wait_req_i` is high. It returns high on the first clock where the request is low and no read hold is active.
- R7: After the forced wait, `ready_o` stays low while `ior_ni` is low and both `memr_ni` and `memw_ni` are high. A low memory strobe or a high `ior_ni` releases it.
- R8: While `rst_ni` is low, both selects and `buf_en_no` are high, `dir_o` is 0 and `ready_o` is high.
- R9: An I/O strobe held active after its wait has ended inserts no further wait. `ready_o` stays high until the strobe goes inactive and then active again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | I/O address |
| aen_i | input | 1 | Address enable, high while DMA owns the bus |
| ior_ni | input | 1 | I/O read strobe, active low |
| iow_ni | input | 1 | I/O write strobe, active low |
| memr_ni | input | 1 | Memory read strobe, active low |
| memw_ni | input | 1 | Memory write strobe, active low |
| wait_req_i | input | 1 | External wait request, active high |
| dma_cs_no | output | 1 | DMA controller select, active low |
| seg_cs_no | output | 1 | Segment register select, active low |
| buf_en_no | output | 1 | Data buffer enable, active low |
| dir_o | output | 1 | Buffer direction, 1 = toward CPU |
| ready_o | output | 1 | Ready to CPU or DMA, low = wait |

## Verification
Assertions check the following on every cycle: the upper-byte and AEN qualification of any active select, the write-only nature of the segment select, the forced wait after a new strobe, and that READY is held or released according to the wait request, read strobe and memory strobes. Only the bench scenarios can show the exact window edges (0x0F against 0x10, 0x83 against 0x84) and the absence of selects for a DMA-owned cycle. They also show the timing of the buffer controls, the count of wait clocks under an extended request, and the reset values.

// File: rtl/io_csel_pkg.sv
package io_csel_pkg;
  typedef enum logic [1:0] {
    WS_IDLE   = 2'd0,
    WS_FORCE  = 2'd1,
    WS_EXTEND = 2'd2
  } wait_st_e;
endpackage

// File: rtl/io_window_match.sv
module io_window_match #(
  parameter int unsigned              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]        BASE      = '0,
  parameter int unsigned              SPAN_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << SPAN_LOG2) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] CMP_MASK = ~LOW_MASK;

  assign hit_o = ((addr_i ^ BASE) & CMP_MASK) == '0;
endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen
  import io_csel_pkg::*;
#(
  parameter bit READ_HOLD = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ior_ni,
  input  logic iow_ni,
  input  logic memr_ni,
  input  logic memw_ni,
  input  logic wait_req_i,
  output logic ready_o
);
  wait_st_e st_q, st_d;
  logic     io_act, io_q, start, rd_hold, hold;

  assign io_act = ~ior_ni | ~iow_ni;
  assign start  = io_act & ~io_q;

  generate
    if (READ_HOLD) begin : g_rd_hold
      assign rd_hold = ~ior_ni & memr_ni & memw_ni;
    end else begin : g_no_rd_hold
      assign rd_hold = 1'b0;
    end
  endgenerate

  assign hold = wait_req_i | rd_hold;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WS_IDLE:             if (start) st_d = WS_FORCE;
      WS_FORCE, WS_EXTEND: st_d = hold ? WS_EXTEND : WS_IDLE;
      default:             st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= WS_IDLE;
      io_q <= 1'b0;
    end else begin
      st_q <= st_d;
      io_q <= io_act;
    end
  end

  assign ready_o = (st_q == WS_IDLE);

  AST_FORCED_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(~ior_ni | ~iow_ni) |=> !ready_o); // R5
  AST_WAIT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && wait_req_i) |=> !ready_o); // R6
  AST_WAIT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !wait_req_i && ior_ni) |=> ready_o); // R6
  AST_NO_REWAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(~ior_ni | ~iow_ni) && (~ior_ni | ~iow_ni)) |=> ready_o); // R9

  generate
    if (READ_HOLD) begin : g_rd_chk
      AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ready_o && !ior_ni && memr_ni && memw_ni) |=> !ready_o); // R7
    end
  endgenerate
endmodule

// File: rtl/io_csel_wait.sv
module io_csel_wait #(
  parameter int unsigned ADDR_W       = 16,
  parameter logic [15:0] DMA_BASE     = 16'h0000,
  parameter int unsigned DMA_SPAN_LOG = 4,
  parameter logic [15:0] SEG_BASE     = 16'h0080,
  parameter int unsigned SEG_SPAN_LOG = 2,
  parameter bit          READ_HOLD    = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              aen_i,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  logic              memr_ni,
  input  logic              memw_ni,
  input  logic              wait_req_i,
  output logic              dma_cs_no,
  output logic              seg_cs_no,
  output logic              buf_en_no,
  output logic              dir_o,
  output logic              ready_o
);
  logic dma_win, seg_win, dma_hit, seg_hit;

  io_window_match #(
    .ADDR_W(ADDR_W), .BASE(ADDR_W'(DMA_BASE)), .SPAN_LOG2(DMA_SPAN_LOG)
  ) i_dma_win (
    .addr_i(addr_i), .hit_o(dma_win)
  );

  io_window_match #(
    .ADDR_W(ADDR_W), .BASE(ADDR_W'(SEG_BASE)), .SPAN_LOG2(SEG_SPAN_LOG)
  ) i_seg_win (
    .addr_i(addr_i), .hit_o(seg_win)
  );

  assign dma_hit = dma_win & ~aen_i & (~ior_ni | ~iow_ni);
  assign seg_hit = seg_win & ~aen_i & ~iow_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_cs_no <= 1'b1;
      seg_cs_no <= 1'b1;
      buf_en_no <= 1'b1;
      dir_o     <= 1'b0;
    end else begin
      dma_cs_no <= ~dma_hit;
      seg_cs_no <= ~seg_hit;
      buf_en_no <= ~(dma_hit | seg_hit);
      dir_o     <= ~ior_ni;
    end
  end

  io_wait_gen #(.READ_HOLD(READ_HOLD)) i_wait (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ior_ni(ior_ni), .iow_ni(iow_ni),
    .memr_ni(memr_ni), .memw_ni(memw_ni),
    .wait_req_i(wait_req_i), .ready_o(ready_o)
  );

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_cs_no || !seg_cs_no) |-> $past(addr_i[ADDR_W-1:8]) == '0); // R1
  AST_DMA_AEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_cs_no |-> ($past(!aen_i) && $past(!ior_ni || !iow_ni))); // R2
  AST_SEG_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seg_cs_no |-> ($past(!iow_ni) && $past(!aen_i))); // R3
  AST_BUF_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_en_no |-> (!dma_cs_no || !seg_cs_no)); // R4
endmodule

// File: tb/test_io_csel_wait.sv
module test_io_csel_wait;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        aen_i = 1'b0, ior_ni = 1'b1, iow_ni = 1'b1;
  logic        memr_ni = 1'b1, memw_ni = 1'b1, wait_req_i = 1'b0;
  logic        dma_cs_no, seg_cs_no, buf_en_no, dir_o, ready_o;

  typedef struct {
    logic  dma, seg, ben, dir, rdy;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  io_csel_wait i_io_csel_wait (
    .clk_i, .rst_ni, .addr_i, .aen_i, .ior_ni, .iow_ni, .memr_ni, .memw_ni,
    .wait_req_i, .dma_cs_no, .seg_cs_no, .buf_en_no, .dir_o, .ready_o
  );

  // driver: set inputs for one cycle and queue the expected outputs after the next edge
  task automatic step(input logic [15:0] a, input logic aen, input logic rd, input logic wr,
                      input logic mr, input logic mw, input logic wq,
                      input logic rdy, input string tag);
    exp_t e;
    logic up0, dwin, swin, act;
    @(negedge clk_i);
    addr_i = a; aen_i = aen; ior_ni = ~rd; iow_ni = ~wr;
    memr_ni = ~mr; memw_ni = ~mw; wait_req_i = wq;
    up0  = (a[15:8] == 8'h00);
    dwin = up0 && (a[7:0] <= 8'h0F);
    swin = up0 && (a[7:0] >= 8'h80) && (a[7:0] <= 8'h83);
    act  = rd || wr;
    e.dma = ~(dwin && !aen && act);
    e.seg = ~(swin && !aen && wr);
    e.ben = e.dma & e.seg;
    e.dir = rd;
    e.rdy = rdy;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if ({dma_cs_no, seg_cs_no, buf_en_no, dir_o, ready_o} !==
            {e.dma, e.seg, e.ben, e.dir, e.rdy}) begin
          n_fail++;
          $display("FAIL %s: dma/seg/ben/dir/rdy got %b%b%b%b%b exp %b%b%b%b%b", e.tag,
                   dma_cs_no, seg_cs_no, buf_en_no, dir_o, ready_o,
                   e.dma, e.seg, e.ben, e.dir, e.rdy);
        end
      end
    end
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R8: reset holds outputs idle even with a hit on the inputs
    iow_ni = 1'b0; ior_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    n_run++;
    if ({dma_cs_no, seg_cs_no, buf_en_no, dir_o, ready_o} !== 5'b11101) begin
      n_fail++;
      $display("FAIL R8: got %b%b%b%b%b exp 11101",
               dma_cs_no, seg_cs_no, buf_en_no, dir_o, ready_o);
    end
    @(negedge clk_i);
    iow_ni = 1'b1; ior_ni = 1'b1;
    rst_ni = 1'b1;
    idle("R8 idle");

    // CPU write to DMA window: one forced wait, then no rewait while held
    step(16'h0005, 0, 0, 1, 0, 0, 0, 1'b0, "R2/R5 write 0x05");
    step(16'h0005, 0, 0, 1, 0, 0, 0, 1'b1, "R6/R9 write held");
    step(16'h0005, 0, 0, 1, 0, 0, 0, 1'b1, "R9 no rewait");
    idle("R2 release");

    // CPU read at top of DMA window, held by read strobe until memory strobe
    step(16'h000F, 0, 1, 0, 0, 0, 0, 1'b0, "R2/R4 read 0x0F");
    step(16'h000F, 0, 1, 0, 0, 0, 0, 1'b0, "R7 read hold");
    step(16'h000F, 0, 1, 0, 0, 0, 0, 1'b0, "R7 read hold 2");
    step(16'h000F, 0, 1, 0, 1, 0, 0, 1'b1, "R7 memr releases");
    idle("R7 idle");

    // read hold released by memory write
    step(16'h0003, 0, 1, 0, 0, 0, 0, 1'b0, "R5 read 0x03");
    step(16'h0003, 0, 1, 0, 0, 1, 0, 1'b1, "R7 memw releases");
    idle("R7 idle 2");

    // just past DMA window
    step(16'h0010, 0, 0, 1, 0, 0, 0, 1'b0, "R2 0x10 no select");
    idle("R2 idle");

    // segment register writes and read
    step(16'h0080, 0, 0, 1, 0, 0, 0, 1'b0, "R3 write 0x80");
    step(16'h0083, 0, 0, 1, 0, 0, 0, 1'b1, "R3 write 0x83");
    idle("R3 idle");
    step(16'h0081, 0, 1, 0, 0, 0, 0, 1'b0, "R3/R4 read 0x81 no select");
    step(16'h0081, 0, 0, 0, 0, 0, 0, 1'b1, "R7 read drop releases");
    step(16'h0084, 0, 0, 1, 0, 0, 0, 1'b0, "R3 write 0x84 no select");
    idle("R3 idle 2");

    // upper byte nonzero
    step(16'h0105, 0, 0, 1, 0, 0, 0, 1'b0, "R1 0x0105");
    idle("R1 idle");
    step(16'hFF82, 0, 0, 1, 0, 0, 0, 1'b0, "R1 0xFF82");
    idle("R1 idle 2");

    // DMA-owned cycles: still a forced wait, no select
    step(16'h0005, 1, 0, 1, 0, 0, 0, 1'b0, "R5 AEN high wait");
    step(16'h0005, 1, 0, 1, 0, 0, 0, 1'b1, "R2 AEN high no select");
    idle("R5 idle");
    step(16'h0082, 1, 0, 1, 0, 0, 0, 1'b0, "R3 AEN high seg");
    idle("R3 idle 3");

    // external wait request extends
    step(16'h0002, 0, 0, 1, 0, 0, 1, 1'b0, "R5 wait start");
    step(16'h0002, 0, 0, 1, 0, 0, 1, 1'b0, "R6 wait held");
    step(16'h0002, 0, 0, 1, 0, 0, 1, 1'b0, "R6 wait held 2");
    step(16'h0002, 0, 0, 1, 0, 0, 0, 1'b1, "R6 wait release");
    idle("R6 idle");
    idle("R6 idle 2");

    @(negedge clk_i);
    @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule